// File: doc/BRIEF.md
# Flash Busy Status Readback Unit

This block forms the byte a flash model or controller returns on its read path. With no embedded operation running and identification mode off, it passes the array byte straight through. While a byte program or a chip erase is running it replaces the array data with a status byte: a polling bit that is the inverse of the final value of bit 7, and a toggle bit that changes on every new read strobe, so that software can tell when the operation has finished.

With identification mode on, the block answers from a small fixed table: the manufacturer code, the device code, or the boot-region lock state, chosen by the read address. The busy flag, operation type, last programmed byte, lock flag and identification flag all come from neighbouring logic. The output is registered, so every read sees the value one clock after its inputs are presented.

Top module: `busy_readback_unit`

## Requirements
- R1: After reset `rd_data` is 0x00, and the toggle state is cleared, so that the first busy read that follows a strobe rising edge returns bit 6 as 1.
- R2: When `busy` is 0 and `id_mode` is 0, `rd_data` equals the `array_byte` presented one clock earlier.
- R3: When `busy` is 1 and `op_type` is 0 (program), bit 7 of `rd_data` is the inverse of bit 7 of `prog_byte` presented one clock earlier.
- R4: When `busy` is 1 and `op_type` is 1 (erase), bit 7 of `rd_data` is 0.
- R5: While `busy` is 1, every clock at which `rd_strobe` is sampled 1 after being sampled 0 inverts the toggle state, and bit 6 of the registered result shows the inverted value in the same clock.
- R6: The toggle state does not change when `rd_strobe` is held high, held low, or rises while `busy` is 0.
- R7: While `busy` is 1, bits 5 to 0 of `rd_data` are 0, `array_byte` has no effect, and the status byte takes priority over identification mode.
- R8: With `busy` 0 and `id_mode` 1, address 0 reads 0x1F and address 1 reads 0x17.
- R9: With `busy` 0 and `id_mode` 1, address 2 reads `lock_flag` in bit 0 (1 = locked) with bits 7 to 1 at 0.
- R10: With `busy` 0 and `id_mode` 1, any other address, including one whose bits above bit 1 are non-zero, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Read strobe; each rising edge is one read access |
| rd_addr | input | ADDR_W | Read address |
| busy | input | 1 | Embedded program or erase in progress |
| op_type | input | 1 | 0 = byte program, 1 = chip erase |
| prog_byte | input | 8 | Byte most recently loaded for programming |
| array_byte | input | 8 | Byte read from the array at `rd_addr` |
| lock_flag | input | 1 | Boot region locked |
| id_mode | input | 1 | Identification mode active |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest behaviour to reach is the toggle bit's dependence on the strobe history rather than on time: a strobe held high over many clocks, a rising edge that lands while idle, and a busy window that opens with an arbitrary leftover toggle state. The bench keeps its own record of the previously sampled strobe and the toggle state, and drives long runs in which the strobe alternates, stays high through busy cycles, and rises during idle sweeps, so every one of those histories is compared against its own arithmetic model of the status byte.

// File: rtl/flash_rb_pkg.sv
package flash_rb_pkg;

    localparam int RB_DATA_W  = 8;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;
    localparam int LOCK_BIT   = 0;

    localparam logic [RB_DATA_W-1:0] MFR_CODE = 8'h1F;
    localparam logic [RB_DATA_W-1:0] DEV_CODE = 8'h17;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_IDENT  = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic     busy;
        op_kind_e kind;
        logic     final_msb;
        logic     toggle;
    } status_in_t;

    // Busy status wins over identification, which wins over the array.
    function automatic src_sel_e pick_source(input logic busy, input logic id_mode);
        if (busy)
            return SRC_STATUS;
        else if (id_mode)
            return SRC_IDENT;
        else
            return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/readback_strobe_toggle.sv
module readback_strobe_toggle (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic busy,
    output logic toggle_next
);
    logic strobe_q;
    logic toggle_q;
    logic strobe_rise;

    assign strobe_rise = strobe & ~strobe_q;
    assign toggle_next = (strobe_rise && busy) ? ~toggle_q : toggle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            toggle_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
            toggle_q <= toggle_next;
        end
    end
endmodule

// File: rtl/readback_status_fmt.sv
module readback_status_fmt
    import flash_rb_pkg::*;
(
    input  status_in_t                st,
    output logic [RB_DATA_W-1:0]      status_byte
);
    logic poll_bit;

    always_comb begin
        case (st.kind)
            OP_ERASE:   poll_bit = 1'b0;
            default:    poll_bit = ~st.final_msb;
        endcase
    end

    for (genvar b = 0; b < RB_DATA_W; b++) begin : g_bits
        if (b == POLL_BIT) begin : g_poll
            assign status_byte[b] = poll_bit;
        end else if (b == TOGGLE_BIT) begin : g_tog
            assign status_byte[b] = st.toggle;
        end else begin : g_zero
            assign status_byte[b] = 1'b0;
        end
    end
endmodule

// File: rtl/readback_id_resp.sv
module readback_id_resp
    import flash_rb_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 lock_flag,
    output logic [RB_DATA_W-1:0] id_byte
);
    localparam int HI_W = ADDR_W - 2;

    logic upper_clear;

    assign upper_clear = (addr[ADDR_W-1:2] == {HI_W{1'b0}});

    always_comb begin
        id_byte = '0;
        if (upper_clear) begin
            case (addr[1:0])
                2'd0:    id_byte = MFR_CODE;
                2'd1:    id_byte = DEV_CODE;
                2'd2:    id_byte[LOCK_BIT] = lock_flag;
                default: id_byte = '0;
            endcase
        end
    end
endmodule

// File: rtl/busy_readback_unit.sv
module busy_readback_unit
    import flash_rb_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              op_type,
    input  logic [7:0]        prog_byte,
    input  logic [7:0]        array_byte,
    input  logic              lock_flag,
    input  logic              id_mode,
    output logic [7:0]        rd_data
);
    logic                 toggle_next;
    status_in_t           st;
    logic [RB_DATA_W-1:0] status_byte;
    logic [RB_DATA_W-1:0] id_byte;
    logic [RB_DATA_W-1:0] next_data;
    src_sel_e             src;

    readback_strobe_toggle u_toggle (
        .clk         (clk),
        .rst         (rst),
        .strobe      (rd_strobe),
        .busy        (busy),
        .toggle_next (toggle_next)
    );

    assign st.busy      = busy;
    assign st.kind      = op_kind_e'(op_type);
    assign st.final_msb = prog_byte[POLL_BIT];
    assign st.toggle    = toggle_next;

    readback_status_fmt u_status (
        .st          (st),
        .status_byte (status_byte)
    );

    readback_id_resp #(.ADDR_W(ADDR_W)) u_ident (
        .addr      (rd_addr),
        .lock_flag (lock_flag),
        .id_byte   (id_byte)
    );

    assign src = pick_source(busy, id_mode);

    always_comb begin
        case (src)
            SRC_STATUS: next_data = status_byte;
            SRC_IDENT:  next_data = id_byte;
            default:    next_data = array_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= next_data;
    end
endmodule

// File: rtl/busy_readback_checker.sv
module busy_readback_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              op_type,
    input logic [7:0]        prog_byte,
    input logic [7:0]        array_byte,
    input logic              lock_flag,
    input logic              id_mode,
    input logic [7:0]        rd_data
);
    logic strobe_d;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b0;
        else     strobe_d <= rd_strobe;
    end

    assign rise = rd_strobe & ~strobe_d;

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !id_mode) |=> rd_data == $past(array_byte)); // R2

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_type) |=> rd_data[7] == ~$past(prog_byte[7])); // R3

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && op_type) |=> rd_data[7] == 1'b0); // R4

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && rise) |=> rd_data[6] != $past(rd_data[6])); // R5

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !rise) |=> $stable(rd_data[6])); // R6

    AST_BUSY_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        busy |=> rd_data[5:0] == 6'd0); // R7

    AST_ID_MFR: assert property (@(posedge clk) disable iff (rst)
        (!busy && id_mode && rd_addr == '0) |=> rd_data == 8'h1F); // R8

    AST_ID_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!busy && id_mode && rd_addr == ADDR_W'(2)) |=> rd_data == {7'd0, $past(lock_flag)}); // R9
endmodule

bind busy_readback_unit busy_readback_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .op_type    (op_type),
    .prog_byte  (prog_byte),
    .array_byte (array_byte),
    .lock_flag  (lock_flag),
    .id_mode    (id_mode),
    .rd_data    (rd_data)
);

// File: tb/busy_readback_unit_bench.sv
`timescale 1ns/1ps
module busy_readback_unit_bench;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_strobe;
    logic [AW-1:0] rd_addr;
    logic          busy;
    logic          op_type;
    logic [7:0]    prog_byte;
    logic [7:0]    array_byte;
    logic          lock_flag;
    logic          id_mode;
    logic [7:0]    rd_data;

    int   checks = 0;
    int   errors = 0;
    logic tog_m  = 1'b0;
    logic prev_s = 1'b0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    busy_readback_unit #(.ADDR_W(AW)) u_busy_readback_unit (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .busy(busy), .op_type(op_type), .prog_byte(prog_byte),
        .array_byte(array_byte), .lock_flag(lock_flag), .id_mode(id_mode),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] model(input logic b, input logic e,
        input logic [7:0] pb, input logic [7:0] arr, input logic lk,
        input logic id, input logic [AW-1:0] a, input logic t);
        if (b)
            return {(e ? 1'b0 : ~pb[7]), t, 6'd0};
        else if (id) begin
            if (a == 0)      return 8'h1F;
            else if (a == 1) return 8'h17;
            else if (a == 2) return {7'd0, lk};
            else             return 8'h00;
        end else
            return arr;
    endfunction

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic step(input logic s, input logic b, input logic e,
        input logic [7:0] pb, input logic [7:0] arr, input logic lk,
        input logic id, input logic [AW-1:0] a, input string req);
        logic [7:0] exp;
        if (s && !prev_s && b) tog_m = ~tog_m;
        prev_s = s;
        rd_strobe = s; busy = b; op_type = e; prog_byte = pb;
        array_byte = arr; lock_flag = lk; id_mode = id; rd_addr = a;
        exp = model(b, e, pb, arr, lk, id, a, tog_m);
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_strobe = 0; rd_addr = '0; busy = 0; op_type = 0;
        prog_byte = 8'hFF; array_byte = 8'hA5; lock_flag = 0; id_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(8'h00, "R1 reset value");

        // First busy read after reset: toggle starts cleared, so bit 6 reads 1 (R1, R5)
        step(1, 1, 0, 8'h00, 8'h3C, 0, 0, '0, "R1 first toggle");
        if (rd_data[6] !== 1'b1) begin
            errors++;
            $display("FAIL R1 actual=%0b expected=1", rd_data[6]);
        end
        checks++;
        step(0, 0, 0, 8'h00, 8'h3C, 0, 0, '0, "R2 leave busy");

        // Idle sweep with strobe rising: data passes, toggle untouched (R2, R6)
        for (int v = 0; v < 256; v++)
            step(v[0], 0, 0, 8'h00, v[7:0], 0, 0, AW'(v * 37), "R2 R6 idle sweep");

        // Program busy sweep: polling bit, toggle per strobe, array and id ignored (R3 R5 R7)
        for (int v = 0; v < 256; v++)
            step(v[0], 1, 0, v[7:0], v[7:0] ^ 8'h5A, 0, v[1], AW'(v % 3), "R3 R5 R7 program busy");

        // Erase busy with strobe held high then pulsed (R4 R6 R5)
        for (int v = 0; v < 64; v++)
            step((v < 20) ? 1'b1 : v[1], 1, 1, 8'h00, 8'hFF, 1, 0, '0, "R4 R5 R6 erase busy");

        // Strobe held low through program busy (R6)
        for (int v = 0; v < 16; v++)
            step(0, 1, 0, 8'h80, 8'h11, 0, 0, '0, "R6 strobe low");

        // Completion: true data returns on all bits (R2)
        step(0, 0, 0, 8'h80, 8'h80, 0, 0, '0, "R2 completion data");

        // Identification sweep over low addresses and lock states (R8 R9 R10)
        for (int v = 0; v < 32; v++)
            step(v[0], 0, 0, 8'h00, 8'hEE, v[4], 1, AW'(v[3:0]), "R8 R9 R10 id sweep");

        // High address bits set must not alias onto the table (R10)
        for (int v = 2; v < AW; v++) begin
            step(0, 0, 0, 8'h00, 8'hEE, 1, 1, AW'((1 << v) | 2), "R10 high address");
            step(0, 0, 0, 8'h00, 8'hEE, 1, 1, AW'(1 << v), "R10 high address");
        end

        step(0, 0, 0, 8'h00, 8'hEE, 1, 1, AW'(2), "R9 locked");
        step(0, 0, 0, 8'h00, 8'hEE, 0, 1, AW'(2), "R9 unlocked");
        step(0, 0, 0, 8'h00, 8'hEE, 0, 1, AW'(0), "R8 manufacturer");
        step(0, 0, 0, 8'h00, 8'hEE, 0, 1, AW'(1), "R8 device");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule